// File: doc/BRIEF.md
# Low-Speed Crystal Failure Monitor

The block supervises an external 32 kHz crystal clock. Its time base is an always-running internal low-speed reference clock, and all of its registers and counters run on that reference. Software arms the monitor through a control bit. The arm request is accepted only when both oscillators are enabled and report ready and an RTC clock source has been chosen. Once armed, the monitor keeps the reference oscillator enabled. If the crystal stops toggling, the monitor blocks the crystal clock from the RTC clock output and cancels any request that locks the multispeed internal oscillator to the crystal. It then reports the failure in one of two ways. In standby it sends a single-cycle wake-up pulse. In any other mode it sets a sticky flag, which drives an interrupt when that interrupt is enabled.

A detection changes no configuration field. The source select, the oscillator enables and the interrupt enable all keep their values, and only the arm bit drops. Software recovers in one of two ways: it picks a different RTC source, or it re-arms after the crystal is fixed. The monitor is cleared by power-on reset and by a backup-domain software reset. It stops checking while the device runs from battery only.

Register map (2-bit address, 8-bit data):

| Address | Access | Contents |
|---------|--------|----------|
| 0 | read/write | control register (fields in R2) |
| 1 | read only | status register (fields in R8) |
| 2 | write only | writing 1 to bit 0 clears the failure flag |
| 3 | none | reads 0 |

Top module: `lse_fail_monitor`

## Requirements
- R1: After power-on reset, every register reads 0. The outputs `ext_osc_en`, `ref_osc_en`, `msi_lock_req`, `fail_irq` and `fail_wake` are all low.
- R2: The control register is at address 0, with these fields:
  - bit0: crystal enable
  - bit1: reference enable
  - bits3:2: RTC source (00 none, 01 crystal, 10 reference, 11 high-speed)
  - bit4: arm
  - bit5: interrupt enable
  - bit6: oscillator lock request

  A write with bit4 set arms the monitor only if, before that write, all of these already hold: crystal enable and `ext_rdy` are 1, reference enable and `ref_rdy` are 1, and the RTC source is not 00. Otherwise the arm bit is ignored.
- R3: While armed, `ref_osc_en` is 1 whatever the reference-enable bit holds.
- R4: Writing 0 to the arm bit does not disarm. The arm bit clears only on power-on reset, on `bd_sw_rst`, or on a detection.
- R5: While armed, a failure is detected at the 8th consecutive reference cycle in which no synchronized crystal rising edge is seen. A crystal with a period of 4 reference cycles is never flagged.
- R6: After a detection with source 01, `rtc_clk` stays low even if the crystal restarts. The control fields keep their values, except that the arm bit reads 0.
- R7: A detection clears the oscillator lock request (bit6 of the control register, output `msi_lock_req`).
- R8: A detection while `standby` is 1 gives a one-cycle `fail_wake` pulse and leaves the flag clear. In any other mode it sets the failure flag (address 1 bit2; bits 0 and 1 mirror `ext_rdy` and `ref_rdy`), and `fail_irq` equals the flag ANDed with the interrupt enable.
- R9: The flag clears only when 1 is written to bit0 at address 2. If a detection and a clear fall in the same cycle, the flag is set. Clearing the flag does not restore the RTC path. A source change or an accepted re-arm does restore it.
- R10: While `vbat_only` is 1, no detection occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | internal low-speed reference clock |
| por_n | input | 1 | power-on reset, active low, asynchronous |
| ext_clk | input | 1 | external crystal clock |
| hse_clk | input | 1 | high-speed RTC source clock |
| bd_sw_rst | input | 1 | backup-domain software reset, synchronous |
| ext_rdy | input | 1 | crystal oscillator ready |
| ref_rdy | input | 1 | reference oscillator ready |
| vbat_only | input | 1 | device on battery only |
| standby | input | 1 | device in standby |
| wr_en | input | 1 | register write strobe |
| addr | input | 2 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data for `addr` |
| ext_osc_en | output | 1 | crystal oscillator enable |
| ref_osc_en | output | 1 | reference oscillator enable |
| rtc_clk | output | 1 | selected RTC clock |
| msi_lock_req | output | 1 | lock internal oscillator to crystal |
| fail_irq | output | 1 | failure interrupt |
| fail_wake | output | 1 | standby wake-up pulse |

## Verification
A flag-clear write and a fresh detection can land on the same reference edge. The bench provokes this by writing the clear bit every cycle from the moment the crystal stops until after detection. The behavioural model, which gives detection priority, then expects `fail_irq` to rise for exactly one cycle before the next clear takes effect. A re-arm write and a detection can also coincide. The model expects the arm bit to read 0 in that case.

// File: rtl/lse_fail_monitor.sv
module lse_fail_monitor #(
  parameter int CNT_W = 3
) (
  input  logic       ref_clk,
  input  logic       por_n,
  input  logic       ext_clk,
  input  logic       hse_clk,
  input  logic       bd_sw_rst,
  input  logic       ext_rdy,
  input  logic       ref_rdy,
  input  logic       vbat_only,
  input  logic       standby,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ext_osc_en,
  output logic       ref_osc_en,
  output logic       rtc_clk,
  output logic       msi_lock_req,
  output logic       fail_irq,
  output logic       fail_wake
);
  localparam logic [CNT_W-1:0] LIMIT = '1;
  localparam logic [1:0] SRC_NONE = 2'd0, SRC_EXT = 2'd1, SRC_REF = 2'd2;

  logic             ext_on, ref_on, irq_en, lock, armed, flag, gone, wake;
  logic [1:0]       src;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       sync;
  logic             en_l;

  wire edge_seen = sync[1] & ~sync[2];
  wire det       = armed & ~vbat_only & ~edge_seen & (cnt == LIMIT);
  wire arm_ok    = ext_on & ext_rdy & ref_on & ref_rdy & (src != SRC_NONE);
  wire wr_ctl    = wr_en & (addr == 2'd0);
  wire wr_clr    = wr_en & (addr == 2'd2) & wdata[0];
  wire arm_acc   = wr_ctl & wdata[4] & arm_ok;

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) sync <= '0;
    else        sync <= {sync[1:0], ext_clk};

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      {ext_on, ref_on, irq_en, lock, armed, flag, gone, wake} <= '0;
      src <= SRC_NONE;
      cnt <= '0;
    end else if (bd_sw_rst) begin
      {ext_on, ref_on, irq_en, lock, armed, flag, gone, wake} <= '0;
      src <= SRC_NONE;
      cnt <= '0;
    end else begin
      cnt  <= (!armed || vbat_only || edge_seen || det) ? '0 : cnt + 1'b1;
      wake <= det & standby;
      if (det && !standby) flag <= 1'b1;
      else if (wr_clr)     flag <= 1'b0;
      if (det)                                          gone <= 1'b1;
      else if (wr_ctl && (wdata[3:2] != src || arm_acc)) gone <= 1'b0;
      if (det)          armed <= 1'b0;
      else if (arm_acc) armed <= 1'b1;
      if (det)         lock <= 1'b0;
      else if (wr_ctl) lock <= wdata[6];
      if (wr_ctl) begin
        ext_on <= wdata[0];
        ref_on <= wdata[1];
        src    <= wdata[3:2];
        irq_en <= wdata[5];
      end
    end
  end

  always_latch
    if (!por_n)       en_l = 1'b0;
    else if (!ext_clk) en_l = ~gone;

  always_comb
    case (src)
      SRC_EXT: rtc_clk = ext_clk & en_l;
      SRC_REF: rtc_clk = ref_clk;
      SRC_NONE: rtc_clk = 1'b0;
      default: rtc_clk = hse_clk;
    endcase

  always_comb
    case (addr)
      2'd0:    rdata = {1'b0, lock, irq_en, armed, src, ref_on, ext_on};
      2'd1:    rdata = {5'b0, flag, ref_rdy, ext_rdy};
      default: rdata = 8'h00;
    endcase

  assign ext_osc_en   = ext_on;
  assign ref_osc_en   = ref_on | armed;
  assign msi_lock_req = lock;
  assign fail_irq     = flag & irq_en;
  assign fail_wake    = wake;

  a_r3_ref_forced: assert property (@(posedge ref_clk) disable iff (!por_n)
    armed |-> ref_osc_en);
  a_r4_arm_sticky: assert property (@(posedge ref_clk) disable iff (!por_n)
    (armed && !det && !bd_sw_rst) |=> armed);
  a_r6_cfg_kept: assert property (@(posedge ref_clk) disable iff (!por_n)
    (det && !wr_ctl && !bd_sw_rst) |=> (!armed && $stable(src) && $stable(ext_on)));
  a_r7_lock_drop: assert property (@(posedge ref_clk) disable iff (!por_n)
    (det && !bd_sw_rst) |=> !msi_lock_req);
  a_r8_wake_pulse: assert property (@(posedge ref_clk) disable iff (!por_n)
    (det && standby && !bd_sw_rst) |=> fail_wake);
  a_r8_flag_set: assert property (@(posedge ref_clk) disable iff (!por_n)
    (det && !standby && !bd_sw_rst) |=> flag);
  a_r9_flag_hold: assert property (@(posedge ref_clk) disable iff (!por_n)
    (flag && !wr_clr && !bd_sw_rst) |=> flag);
  a_r10_vbat_quiet: assert property (@(posedge ref_clk) disable iff (!por_n)
    vbat_only |-> !det);
endmodule

// File: tb/lse_fail_monitor_bench.sv
module lse_fail_monitor_bench;
  logic ref_clk = 0, por_n = 0, ext_clk = 0, hse_clk = 0, bd_sw_rst = 0;
  logic ext_rdy = 0, ref_rdy = 0, vbat_only = 0, standby = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ext_osc_en, ref_osc_en, rtc_clk, msi_lock_req, fail_irq, fail_wake;

  lse_fail_monitor u_lse_fail_monitor (.*);

  always #4 ref_clk = ~ref_clk;

  int compared = 0, mismatched = 0, cyc = 0;
  bit ext_run = 0;
  int ph = 0;

  always @(negedge ref_clk)
    if (!ext_run) ext_clk <= 0;
    else begin
      ph = ph + 1;
      if (ph >= 2) begin ph = 0; ext_clk <= ~ext_clk; end
    end

  // behavioural model state
  bit m_ext_on, m_ref_on, m_irq_en, m_lock, m_armed, m_flag, m_gone, m_wake, m_en;
  int m_src, m_idle;
  bit h1, h2, h3;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge ref_clk) begin
    bit e, d, ok, wc, wl;
    if (!por_n) begin
      {m_ext_on, m_ref_on, m_irq_en, m_lock, m_armed, m_flag, m_gone, m_wake, m_en} = '0;
      {h1, h2, h3} = '0; m_src = 0; m_idle = 0;
    end else begin
      e  = h2 && !h3;
      d  = m_armed && !vbat_only && !e && m_idle == 7;
      ok = m_ext_on && ext_rdy && m_ref_on && ref_rdy && m_src != 0;
      wc = wr_en && addr == 0;
      wl = wr_en && addr == 2 && wdata[0];
      h3 = h2; h2 = h1; h1 = ext_clk;
      if (bd_sw_rst) begin
        {m_ext_on, m_ref_on, m_irq_en, m_lock, m_armed, m_flag, m_gone, m_wake} = '0;
        m_src = 0; m_idle = 0;
      end else begin
        m_idle = (!m_armed || vbat_only || e || d) ? 0 : m_idle + 1;
        m_wake = d && standby;
        if (d && !standby) m_flag = 1; else if (wl) m_flag = 0;
        if (d) m_gone = 1;
        else if (wc && (int'(wdata[3:2]) != m_src || (wdata[4] && ok))) m_gone = 0;
        if (d) m_armed = 0; else if (wc && wdata[4] && ok) m_armed = 1;
        if (d) m_lock = 0; else if (wc) m_lock = wdata[6];
        if (wc) begin
          m_ext_on = wdata[0]; m_ref_on = wdata[1];
          m_src = int'(wdata[3:2]); m_irq_en = wdata[5];
        end
      end
    end
    #2;
    cyc++;
    if (por_n) begin
      int exp_rd, exp_rtc;
      if (!ext_clk) m_en = !m_gone;
      exp_rd = (addr == 0) ? {m_lock, m_irq_en, m_armed, m_src[1:0], m_ref_on, m_ext_on} :
               (addr == 1) ? {m_flag, ref_rdy, ext_rdy} : 0;
      chk("R2 rdata", rdata, exp_rd);
      chk("R3 ref_osc_en", ref_osc_en, m_ref_on | m_armed);
      chk("R7 msi_lock_req", msi_lock_req, m_lock);
      chk("R8 fail_irq", fail_irq, m_flag & m_irq_en);
      chk("R8 fail_wake", fail_wake, m_wake);
      if (m_src != 2) begin
        exp_rtc = (m_src == 1) ? (ext_clk & m_en) : 0;
        chk("R6 rtc_clk", rtc_clk, exp_rtc);
      end
    end
    if (cyc > 100000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge ref_clk); endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge ref_clk); wr_en = 1; addr = a; wdata = d;
    @(negedge ref_clk); wr_en = 0; addr = 0;
  endtask

  // ctrl: bit0 ext_on, bit1 ref_on, [3:2] src, bit4 arm, bit5 irq_en, bit6 lock
  localparam logic [7:0] CFG = 8'h67;   // lock, irq_en, src=01, ref_on, ext_on
  localparam logic [7:0] ARM = 8'h77;

  task automatic stop_and_wait(output int lat);
    lat = 0;
    @(negedge ref_clk); ext_run = 0;
    while (!fail_irq && !fail_wake && lat < 40) begin @(negedge ref_clk); lat++; end
  endtask

  initial begin
    int lat;
    idle(3); #1 por_n = 1;
    idle(1);
    addr = 0; #1 chk("R1 ctrl after reset", rdata, 0);
    chk("R1 outputs after reset", {ext_osc_en, ref_osc_en, msi_lock_req, fail_irq, fail_wake}, 0);
    ext_run = 1; ext_rdy = 1;
    wr(0, CFG); wr(0, ARM);             // ref_rdy low: arm ignored
    #1 chk("R2 arm ignored while ref not ready", rdata[4], 0);
    ref_rdy = 1;
    wr(0, ARM);
    #1 chk("R2 arm accepted", rdata[4], 1);
    wr(0, 8'h75);                      // ref_on=0, arm stays requested
    #1 chk("R3 ref forced while armed", ref_osc_en, 1);
    wr(0, 8'h65);                      // arm bit written 0
    #1 chk("R4 arm not cleared by software", rdata[4], 1);
    wr(0, CFG); idle(40);
    chk("R5 running crystal never flagged", fail_irq, 0);
    // detection with clear writes every cycle
    @(negedge ref_clk); ext_run = 0; wr_en = 1; addr = 2; wdata = 8'h01;
    lat = 0;
    while (!fail_irq && lat < 40) begin @(negedge ref_clk); lat++; end
    chk("R9 detection beats same-cycle clear", fail_irq, 1);
    chk("R5 detection latency within 8..16", (lat >= 8 && lat <= 16), 1);
    @(negedge ref_clk); wr_en = 0; addr = 0;
    #1 chk("R9 flag cleared by write", fail_irq, 0);
    chk("R6 source and enables kept", rdata[3:0], 4'h7);
    chk("R7 lock cleared", msi_lock_req, 0);
    ext_run = 1; idle(20);
    chk("R9 clear does not restore rtc", rtc_clk, 0);
    // re-arm, standby detection
    wr(0, ARM); idle(10); standby = 1;
    stop_and_wait(lat);
    chk("R8 standby gives wake", fail_wake, 1);
    addr = 1; idle(2); #1 chk("R8 no flag in standby", rdata[2], 0);
    standby = 0; addr = 0; ext_run = 1; idle(6);
    // vbat suppresses detection
    wr(0, ARM); vbat_only = 1; idle(4); ext_run = 0; idle(30);
    chk("R10 no detection on battery", fail_irq, 0);
    vbat_only = 0;
    stop_and_wait(lat);
    chk("R10 detection resumes off battery", fail_irq, 1);
    ext_run = 1; idle(6);
    wr(0, ARM); idle(4);
    @(negedge ref_clk); bd_sw_rst = 1; @(negedge ref_clk); bd_sw_rst = 0;
    #1 chk("R4 backup reset disarms", rdata, 0);
    addr = 1; #1 chk("R4 backup reset clears flag", rdata[2], 0);
    addr = 0; idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule